// File: doc/BRIEF.md
# Converter Result Buffer with Bypass

This block sits between the result stage of a sampling converter and its output register. Each result word is 18 bits. Bit 17 is the overflow flag, bit 16 is a second copy of the most significant data bit, and bits 15:0 are the conversion data. The block stores and returns all 18 bits unchanged and decodes none of them.

When `fifoMode` is high, every completed conversion goes into a 16-word first-in first-out buffer. The oldest stored word is always shown on `outWord`, so no read is needed to see it. A host walks through the stored words by pulsing the active-low `readN` line. When `fifoMode` is low, the buffer is bypassed and `outWord` follows the converter directly. Two status outputs report how full the buffer is. Holding `fifoMode` low while `readN` is also low empties the buffer.

`readN` is sampled in the `clk` domain. An edge means the value seen at this clock edge differs from the value seen at the previous clock edge.

Top module: `convFifo`

## Requirements
- R1: A stored word comes back on `outWord` with all 18 bits unchanged, including bit 17 (overflow) and bit 16 (MSB copy).
- R2: With `fifoMode`=0, `outWord` equals `convWord`, and `convDone` and edges on `readN` change neither the stored contents nor the status.
- R3: With `fifoMode`=1, every `convDone` pulse stores `convWord` when the buffer is not full, whatever the level of `readN`.
- R4: When a word is written into an empty buffer, it appears on `outWord` one clock later. It stays there until a read removes it.
- R5: A rising edge on `readN` while two or more words are held removes the head word. The next stored word appears on `outWord` one clock later.
- R6: A falling edge on `readN` while exactly one word is held empties the buffer. `outWord` keeps showing that last word.
- R7: A read while the buffer is empty leaves `outWord` and the status unchanged.
- R8: A `convDone` while 16 words are held is dropped, and that word never reaches `outWord`.
- R9: Status {`levelHi`,`levelLo`} is {0,1} for 0 words, {0,0} for 1 to 7 words, {1,0} for 8 to 15 words, and {1,1} for 16 words.
- R10: A clock edge with `fifoMode`=0 and `readN`=0 empties the buffer. `fifoMode`=0 with `readN`=1 does not.
- R11: After `rstN` is asserted, the status is empty and, in buffer mode, `outWord` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoMode | input | 1 | 1: buffer in the data path; 0: bypass |
| readN | input | 1 | Active-low read line; its edges drive reads |
| convDone | input | 1 | One-cycle pulse when a conversion completes |
| convWord | input | 18 | Result word: overflow, MSB copy, 16 data bits |
| outWord | output | 18 | Word presented to the output register |
| levelHi | output | 1 | Fill status, upper bit |
| levelLo | output | 1 | Fill status, lower bit |

## Verification
The bench fills the buffer to exactly 16 words and then offers a 17th, distinctive word. A design that wrapped its write pointer would later show that word, or show a wrong count. It then drains the buffer one word at a time and checks each status threshold, 8 to 7 words in particular, where an off-by-one compare would report the wrong half. The last word must be removed by a falling edge rather than a rising one; a design that popped on the rising edge would blank or corrupt the output, or leave the status non-empty. It also checks that bypass mode with `readN` high keeps the contents, while bypass mode with `readN` low clears them. A design that cleared on bypass alone, or never cleared, would present the wrong head word afterwards.

// File: rtl/convFifoPkg.sv
package convFifoPkg;
  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic push;      // store convWord at the write slot
    logic pop;       // drop head, show the next stored word
    logic drain;     // drop the last word, keep it on the output
    logic clear;     // reset pointers to empty
    logic loadHead;  // incoming word becomes the shown word now
  } fifoStrobe_t;
endpackage

// File: rtl/convFifoCtrl.sv
module convFifoCtrl
  import convFifoPkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fifoMode,
  input  logic        readN,
  input  logic        convDone,
  output fifoStrobe_t strobe,
  output logic        levelHi,
  output logic        levelLo
);
  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam int HALF  = DEPTH / 2;

  logic             readPrev;
  logic [CNT_W-1:0] count;
  logic             readRise, readFall;
  logic             isEmpty, isOne, isFull;

  assign readRise = readN & ~readPrev;
  assign readFall = ~readN & readPrev;
  assign isEmpty  = (count == '0);
  assign isOne    = (count == CNT_W'(1));
  assign isFull   = (count == CNT_W'(DEPTH));

  always_comb begin
    strobe.clear    = !fifoMode && !readN;
    strobe.push     = fifoMode && convDone && !isFull;
    strobe.pop      = fifoMode && readRise && !isEmpty && !isOne;
    strobe.drain    = fifoMode && readFall && isOne;
    strobe.loadHead = strobe.push && (isEmpty || strobe.drain);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readPrev <= 1'b1;
      count    <= '0;
    end else begin
      readPrev <= readN;
      if (strobe.clear)
        count <= '0;
      else
        count <= count + CNT_W'(strobe.push) - CNT_W'(strobe.pop)
                       - CNT_W'(strobe.drain);
    end
  end

  assign levelHi = (count >= CNT_W'(HALF));
  assign levelLo = isEmpty || isFull;
endmodule

// File: rtl/convFifoData.sv
module convFifoData
  import convFifoPkg::*;
#(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 16   // power of two: pointers wrap naturally
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoMode,
  input  logic [WORD_W-1:0] convWord,
  input  fifoStrobe_t       strobe,
  output logic [WORD_W-1:0] outWord
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, rdNext;
  logic [WORD_W-1:0] shownWord;

  assign rdNext = rdPtr + PTR_W'(1);

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= convWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      shownWord <= '0;
    end else begin
      if (strobe.clear) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (strobe.push)                wrPtr <= wrPtr + PTR_W'(1);
        if (strobe.pop || strobe.drain) rdPtr <= rdNext;
      end
      if (strobe.loadHead)  shownWord <= convWord;
      else if (strobe.pop)  shownWord <= mem[rdNext];
    end
  end

  assign outWord = fifoMode ? shownWord : convWord;
endmodule

// File: rtl/convFifo.sv
module convFifo
  import convFifoPkg::*;
#(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoMode,
  input  logic              readN,
  input  logic              convDone,
  input  logic [WORD_W-1:0] convWord,
  output logic [WORD_W-1:0] outWord,
  output logic              levelHi,
  output logic              levelLo
);
  fifoStrobe_t strobe;

  convFifoCtrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .readN(readN),
    .convDone(convDone), .strobe(strobe),
    .levelHi(levelHi), .levelLo(levelLo)
  );

  convFifoData #(.WORD_W(WORD_W), .DEPTH(DEPTH)) data (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .convWord(convWord),
    .strobe(strobe), .outWord(outWord)
  );
endmodule

// File: rtl/convFifoChecker.sv
module convFifoChecker #(
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              fifoMode,
  input logic              readN,
  input logic              convDone,
  input logic [WORD_W-1:0] convWord,
  input logic [WORD_W-1:0] outWord,
  input logic              levelHi,
  input logic              levelLo
);
  logic statEmpty, statFull;
  assign statEmpty = !levelHi && levelLo;
  assign statFull  = levelHi && levelLo;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoMode && !readN) |=> statEmpty);  // R10

  AST_BYPASS_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoMode && readN) |=> $stable({levelHi, levelLo}));  // R2

  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (fifoMode && statFull && $stable(readN)) |=> statFull);  // R8

  AST_FIRST_WORD_SHOWN: assert property (@(posedge clk) disable iff (!rstN)
    (fifoMode && statEmpty && convDone) |=> (!fifoMode || outWord == $past(convWord)));  // R4

  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (fifoMode && statEmpty && !convDone) |=> (!fifoMode || $stable(outWord)));  // R7
endmodule

bind convFifo convFifoChecker #(.WORD_W(WORD_W)) chk (
  .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .readN(readN),
  .convDone(convDone), .convWord(convWord), .outWord(outWord),
  .levelHi(levelHi), .levelLo(levelLo)
);

// File: tb/convFifo_test.sv
`timescale 1ns/1ps
module convFifo_test;
  localparam int W = 18;

  typedef struct packed {
    logic         mode;
    logic         rdN;
    logic         done;
    logic [W-1:0] word;
    logic [W-1:0] expOut;
    logic         expHi;
    logic         expLo;
  } vec_t;

  localparam logic [W-1:0] A1 = 18'h2A001, A2 = 18'h10002, A3 = 18'h1F003;
  localparam logic [W-1:0] B1 = 18'h0BEEF, B2 = 18'h0CAFE, C1 = 18'h3C009;

  localparam vec_t VEC [0:11] = '{
    '{1'b1, 1'b1, 1'b1, A1,    A1, 1'b0, 1'b0},  // R4 R1 first word shown, ovf bit kept
    '{1'b1, 1'b1, 1'b1, A2,    A1, 1'b0, 1'b0},  // R3 second write, head held
    '{1'b1, 1'b0, 1'b1, A3,    A1, 1'b0, 1'b0},  // R3 write with read low
    '{1'b1, 1'b1, 1'b0, 18'h0, A2, 1'b0, 1'b0},  // R5 rise pops
    '{1'b1, 1'b0, 1'b0, 18'h0, A2, 1'b0, 1'b0},  // R6 fall with 2 words: no change
    '{1'b1, 1'b1, 1'b0, 18'h0, A3, 1'b0, 1'b0},  // R5 second pop
    '{1'b1, 1'b0, 1'b0, 18'h0, A3, 1'b0, 1'b1},  // R6 fall drains last word
    '{1'b1, 1'b1, 1'b0, 18'h0, A3, 1'b0, 1'b1},  // R7 read while empty
    '{1'b0, 1'b1, 1'b1, B1,    B1, 1'b0, 1'b1},  // R2 bypass passes word through
    '{1'b1, 1'b1, 1'b0, B2,    A3, 1'b0, 1'b1},  // R2 bypass write was ignored
    '{1'b1, 1'b1, 1'b1, C1,    C1, 1'b0, 1'b0},  // R4 new head
    '{1'b1, 1'b0, 1'b0, 18'h0, C1, 1'b0, 1'b1}   // R6 drain single word
  };

  logic clk = 1'b0;
  logic rstN, fifoMode, readN, convDone;
  logic [W-1:0] convWord, outWord;
  logic levelHi, levelLo;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  convFifo uut (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .readN(readN),
    .convDone(convDone), .convWord(convWord), .outWord(outWord),
    .levelHi(levelHi), .levelLo(levelLo)
  );

  task automatic step(input logic m, input logic r, input logic d, input logic [W-1:0] w);
    fifoMode = m; readN = r; convDone = d; convWord = w;
    @(posedge clk); #1;
  endtask

  task automatic check(input string tag, input logic [W-1:0] eo, input logic eh, input logic el);
    checks++;
    if (outWord !== eo || levelHi !== eh || levelLo !== el) begin
      errors++;
      $display("FAIL %s: out=%h hi=%b lo=%b, expected out=%h hi=%b lo=%b",
               tag, outWord, levelHi, levelLo, eo, eh, el);
    end
  endtask

  // R9 status code from the word count
  function automatic logic [1:0] expLevel(input int n);
    if (n == 0) return 2'b01;
    if (n < 8) return 2'b00;
    if (n < 16) return 2'b10;
    return 2'b11;
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] lv;
    rstN = 1'b0; fifoMode = 1'b1; readN = 1'b1; convDone = 1'b0; convWord = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset state", 18'h0, 1'b0, 1'b1);
    rstN = 1'b1;

    for (int i = 0; i < 12; i++) begin
      step(VEC[i].mode, VEC[i].rdN, VEC[i].done, VEC[i].word);
      check($sformatf("table row %0d", i), VEC[i].expOut, VEC[i].expHi, VEC[i].expLo);
    end

    // Fill to full, then overflow (R8, R9)
    step(1'b1, 1'b1, 1'b0, 18'h0);
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'b1, 1'b1, 18'h00100 + W'(i));
      lv = expLevel(i + 1);
      check($sformatf("R9 fill count %0d", i + 1), 18'h00100, lv[1], lv[0]);
    end
    step(1'b1, 1'b1, 1'b1, 18'h3FFFF);
    check("R8 write to full dropped", 18'h00100, 1'b1, 1'b1);

    // Drain with read pulses (R5, R9)
    for (int k = 1; k < 16; k++) begin
      step(1'b1, 1'b0, 1'b0, 18'h0);
      step(1'b1, 1'b1, 1'b0, 18'h0);
      lv = expLevel(16 - k);
      check($sformatf("R5 pop %0d", k), 18'h00100 + W'(k), lv[1], lv[0]);
    end
    step(1'b1, 1'b0, 1'b0, 18'h0);
    check("R6 last word drained", 18'h0010F, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b0, 18'h0);
    check("R7 read after empty", 18'h0010F, 1'b0, 1'b1);

    // Clear combination (R10)
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, 18'h00200 + W'(i));
    step(1'b0, 1'b1, 1'b0, 18'h0);
    step(1'b1, 1'b1, 1'b0, 18'h0);
    check("R10 bypass with read high keeps data", 18'h00200, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 18'h0);
    check("R10 clear combination", 18'h0, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b1, 18'h2E0E0);
    check("R10 new head after clear", 18'h2E0E0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 18'h0);
    check("R10 only one word held after clear", 18'h2E0E0, 1'b0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule